// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Engine

This block is the receive half of one DMA channel. It takes a byte stream from a peripheral, one byte per handshake with an end-of-packet marker, and places the bytes into memory buffers described by a linked list of data descriptors. Each descriptor is four 32-bit words: the next-descriptor pointer at offset 0, the buffer start at offset 4, a flags word at offset 8 (bit 0 end-of-list, bit 4 interrupt request, bit 11 input end-of-packet, other bits kept as they are) and the buffer end address ("after", exclusive) at offset 12. A channel context descriptor holds a flags word at offset 4 whose bit 15 is the disable bit.

A descriptor is closed when its buffer is full or when a byte marked end-of-packet lands. On close the engine writes the flags word back and then overwrites the after field with the real end pointer, so software can read how many bytes arrived. It raises raw interrupt set pulses for the register block next to it, and then either follows the next pointer or, at end of list, marks the context disabled and stops. A new start pulse restarts the chain.

Memory is reached through a word master port with byte enables. Reads return data on the cycle after the request; writes complete on the request cycle.

Top module: `dma_in_engine`

## Requirements
- R1: After reset the engine is idle: `in_ready_o`, `mem_req_o`, `eol_o` and `intr_set_o` are all 0. In idle, `start_i` latches the first descriptor and context pointers, clears `eol_o` and begins fetching the descriptor words; `start_i` is ignored while busy.
- R2: Each accepted byte is written to the word holding the current buffer pointer with exactly one byte enable set, lane = pointer bits [1:0], data in bits [8*lane+7:8*lane]; the pointer then advances by one, so bytes outside the buffer are never changed.
- R3: A descriptor closes when the pointer reaches its after address; a descriptor whose buffer start equals its after address closes without taking any byte.
- R4: A byte marked end-of-packet closes the descriptor after that byte is written, even with room left.
- R5: On close the after word (offset 12) is overwritten with the final pointer, one cycle after the flags word is written.
- R6: If flags bit 4 is set, the close raises `intr_set_o` bits 0 and 1 together.
- R7: If the close was caused by end-of-packet, the written-back flags word has bit 11 set and `intr_set_o` bit 3 is raised; bit 2 is never raised.
- R8: `intr_upd_o` pulses only in a cycle where `intr_set_o | raw_intr_i` differs from `raw_intr_i`.
- R9: If flags bit 0 is clear, the engine fetches the descriptor at the next pointer (offset 0) and resumes filling at its buffer start (offset 4).
- R10: If flags bit 0 is set, the engine reads the context word at context pointer + 4, writes it back with bit 15 set, raises `eol_o` and holds `in_ready_o` low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start the chain from the given pointers |
| desc_ptr_i | input | AW | Address of the first data descriptor |
| ctx_ptr_i | input | AW | Address of the context descriptor |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_eop_i | input | 1 | Byte is the last of a packet |
| in_ready_o | output | 1 | Engine accepts the byte this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| raw_intr_i | input | 4 | Current raw interrupt value held by the register block |
| intr_set_o | output | 4 | Raw interrupt bits to set this cycle |
| intr_upd_o | output | 1 | Raw interrupt value changes this cycle |
| eol_o | output | 1 | Channel reached end of list |
| busy_o | output | 1 | Engine not idle |

## Verification
The bench targets buffers that begin and end in the middle of a word, where a design writing whole words would smash the guard bytes around the buffer, and a zero-length descriptor, which a design testing fullness only after a write would overrun into the following memory. An early end-of-packet checks that the after field holds the short fill level and that bit 11 lands in the written-back flags; a design that wrote the original after value or missed the flag would leave software unable to find the packet end. It also drives bytes after end of list, which a design without back-pressure would write somewhere, and walks the raw interrupt value so that a close whose bits are already set must not strobe the update.

// File: rtl/dma_in_pkg.sv
package dma_in_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);

    // descriptor word offsets (bytes)
    localparam int OFF_NEXT  = 0;
    localparam int OFF_BUF   = 4;
    localparam int OFF_FLAGS = 8;
    localparam int OFF_AFTER = 12;
    localparam int OFF_CTXFL = 4;

    // flag bit positions
    localparam int FL_EOL    = 0;
    localparam int FL_INTR   = 4;
    localparam int FL_IN_EOP = 11;
    localparam int CTX_DIS   = 15;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_NEXT, S_RD_BUF, S_RD_FLAGS, S_RD_AFTER, S_GOT_AFTER,
        S_FILL, S_WB_FLAGS, S_WB_AFTER, S_CTX_RD, S_CTX_WR
    } eng_state_e;
endpackage

// File: rtl/dma_in_lane.sv
module dma_in_lane
    import dma_in_pkg::*;
(
    input  logic [LANE_W-1:0] lane_i,
    input  logic [7:0]        byte_i,
    output logic [LANES-1:0]  be_o,
    output logic [WORD_W-1:0] data_o
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign be_o[l]          = (lane_i == LANE_W'(l));
            assign data_o[8*l +: 8] = byte_i;
        end
    endgenerate
endmodule

// File: rtl/dma_in_intr.sv
module dma_in_intr (
    input  logic       fire_i,
    input  logic       eop_i,
    input  logic       dintr_i,
    input  logic [3:0] raw_i,
    output logic [3:0] set_o,
    output logic       upd_o
);
    always_comb begin
        set_o = 4'b0000;
        if (fire_i) set_o = {eop_i, 1'b0, dintr_i, dintr_i};
        upd_o = |(set_o & ~raw_i);
    end
endmodule

// File: rtl/dma_in_engine.sv
module dma_in_engine
    import dma_in_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] desc_ptr_i,
    input  logic [AW-1:0] ctx_ptr_i,
    input  logic          in_valid_i,
    input  logic [7:0]    in_data_i,
    input  logic          in_eop_i,
    output logic          in_ready_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [3:0]    mem_be_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    input  logic [3:0]    raw_intr_i,
    output logic [3:0]    intr_set_o,
    output logic          intr_upd_o,
    output logic          eol_o,
    output logic          busy_o
);
    typedef struct packed {
        eng_state_e        state;
        logic [AW-1:0]     desc;
        logic [AW-1:0]     ctx;
        logic [AW-1:0]     nxt;
        logic [AW-1:0]     ptr;
        logic [AW-1:0]     after;
        logic [WORD_W-1:0] flags;
        logic              eop_hit;
        logic              eol;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [LANES-1:0]  lane_be;
    logic [WORD_W-1:0] lane_data;
    logic              fire;
    logic [AW-1:0]     ptr_inc;

    assign ptr_inc = eng_q.ptr + AW'(1);

    dma_in_lane u_lane (
        .lane_i (eng_q.ptr[LANE_W-1:0]),
        .byte_i (in_data_i),
        .be_o   (lane_be),
        .data_o (lane_data)
    );

    dma_in_intr u_intr (
        .fire_i  (fire),
        .eop_i   (eng_q.eop_hit),
        .dintr_i (eng_q.flags[FL_INTR]),
        .raw_i   (raw_intr_i),
        .set_o   (intr_set_o),
        .upd_o   (intr_upd_o)
    );

    always_comb begin
        eng_d       = eng_q;
        in_ready_o  = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = eng_q.desc;
        mem_be_o    = '1;
        mem_wdata_o = '0;
        fire        = 1'b0;
        case (eng_q.state)
            S_IDLE: begin
                if (start_i) begin
                    eng_d.desc  = desc_ptr_i;
                    eng_d.ctx   = ctx_ptr_i;
                    eng_d.eol   = 1'b0;
                    eng_d.state = S_RD_NEXT;
                end
            end
            S_RD_NEXT: begin
                mem_req_o   = 1'b1;
                mem_addr_o  = eng_q.desc + AW'(OFF_NEXT);
                eng_d.state = S_RD_BUF;
            end
            S_RD_BUF: begin
                eng_d.nxt   = AW'(mem_rdata_i);
                mem_req_o   = 1'b1;
                mem_addr_o  = eng_q.desc + AW'(OFF_BUF);
                eng_d.state = S_RD_FLAGS;
            end
            S_RD_FLAGS: begin
                eng_d.ptr   = AW'(mem_rdata_i);
                mem_req_o   = 1'b1;
                mem_addr_o  = eng_q.desc + AW'(OFF_FLAGS);
                eng_d.state = S_RD_AFTER;
            end
            S_RD_AFTER: begin
                eng_d.flags = mem_rdata_i;
                mem_req_o   = 1'b1;
                mem_addr_o  = eng_q.desc + AW'(OFF_AFTER);
                eng_d.state = S_GOT_AFTER;
            end
            S_GOT_AFTER: begin
                eng_d.after   = AW'(mem_rdata_i);
                eng_d.eop_hit = 1'b0;
                eng_d.state   = S_FILL;
            end
            S_FILL: begin
                if (eng_q.ptr == eng_q.after) begin
                    eng_d.state = S_WB_FLAGS;
                end else begin
                    in_ready_o = 1'b1;
                    if (in_valid_i) begin
                        mem_req_o   = 1'b1;
                        mem_we_o    = 1'b1;
                        mem_addr_o  = {eng_q.ptr[AW-1:LANE_W], LANE_W'(0)};
                        mem_be_o    = lane_be;
                        mem_wdata_o = lane_data;
                        eng_d.ptr   = ptr_inc;
                        if (ptr_inc == eng_q.after || in_eop_i) begin
                            eng_d.eop_hit = in_eop_i;
                            eng_d.state   = S_WB_FLAGS;
                        end
                    end
                end
            end
            S_WB_FLAGS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = eng_q.desc + AW'(OFF_FLAGS);
                mem_wdata_o = eng_q.flags | (WORD_W'(eng_q.eop_hit) << FL_IN_EOP);
                fire        = 1'b1;
                eng_d.state = S_WB_AFTER;
            end
            S_WB_AFTER: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = eng_q.desc + AW'(OFF_AFTER);
                mem_wdata_o = WORD_W'(eng_q.ptr);
                if (eng_q.flags[FL_EOL]) begin
                    eng_d.state = S_CTX_RD;
                end else begin
                    eng_d.desc  = eng_q.nxt;
                    eng_d.state = S_RD_NEXT;
                end
            end
            S_CTX_RD: begin
                mem_req_o   = 1'b1;
                mem_addr_o  = eng_q.ctx + AW'(OFF_CTXFL);
                eng_d.state = S_CTX_WR;
            end
            S_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = eng_q.ctx + AW'(OFF_CTXFL);
                mem_wdata_o = mem_rdata_i | (WORD_W'(1) << CTX_DIS);
                eng_d.eol   = 1'b1;
                eng_d.state = S_IDLE;
            end
            default: eng_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.state <= S_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign eol_o  = eng_q.eol;
    assign busy_o = (eng_q.state != S_IDLE);
endmodule

// File: rtl/dma_in_engine_chk.sv
module dma_in_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [AW-1:0] desc_ptr_i,
    input logic [AW-1:0] ctx_ptr_i,
    input logic          in_valid_i,
    input logic [7:0]    in_data_i,
    input logic          in_eop_i,
    input logic          in_ready_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [3:0]    mem_be_o,
    input logic [31:0]   mem_wdata_o,
    input logic [31:0]   mem_rdata_i,
    input logic [3:0]    raw_intr_i,
    input logic [3:0]    intr_set_o,
    input logic          intr_upd_o,
    input logic          eol_o,
    input logic          busy_o
);
    AST_BACKPRESSURE_AT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> !in_ready_o); // R10
    AST_ONE_LANE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |-> (mem_req_o && mem_we_o && $countones(mem_be_o) == 1)); // R2
    AST_DATA_INTR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_set_o[0] == intr_set_o[1]) && !intr_set_o[2]); // R6
    AST_UPD_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        intr_upd_o |-> ((intr_set_o | raw_intr_i) != raw_intr_i)); // R8
    AST_SET_WITH_FLAGS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_set_o != 4'b0) |-> (mem_req_o && mem_we_o)); // R7
    AST_EOL_RISE_WRITES_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eol_o) |-> !busy_o); // R10
    AST_START_CLEARS_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (!eol_o && busy_o)); // R1
endmodule

bind dma_in_engine dma_in_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_dma_in_engine.sv
module tb_dma_in_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] desc_ptr_i = '0, ctx_ptr_i = '0;
    logic in_valid_i = 1'b0, in_eop_i = 1'b0;
    logic [7:0] in_data_i = '0;
    logic in_ready_o, mem_req_o, mem_we_o, intr_upd_o, eol_o, busy_o;
    logic [AW-1:0] mem_addr_o;
    logic [3:0] mem_be_o, intr_set_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic [3:0] raw_intr = '0;

    int tests = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_in_engine #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
        .ctx_ptr_i(ctx_ptr_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_eop_i(in_eop_i), .in_ready_o(in_ready_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .raw_intr_i(raw_intr),
        .intr_set_o(intr_set_o), .intr_upd_o(intr_upd_o), .eol_o(eol_o), .busy_o(busy_o)
    );

    // memory seen by the DUT and the expected image
    logic [31:0] mem [0:255];
    logic [31:0] expm [0:255];

    always @(posedge clk) begin
        if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[9:2]];
        if (mem_req_o && mem_we_o)
            for (int l = 0; l < 4; l++)
                if (mem_be_o[l]) mem[mem_addr_o[9:2]][8*l +: 8] <= mem_wdata_o[8*l +: 8];
        raw_intr <= raw_intr | intr_set_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic [3:0] exp_set_q [$];
    int m_desc, m_ptr, m_after, m_ctx;

    function automatic logic [31:0] rdw(input int a);
        return expm[a[9:2]];
    endfunction
    task automatic wrw(input int a, input logic [31:0] v);
        expm[a[9:2]] = v;
    endtask

    task automatic m_load(input int a);
        m_desc  = a;
        m_ptr   = rdw(a + 4);
        m_after = rdw(a + 12);
        if (m_ptr == m_after) m_close(1'b0);
    endtask

    task automatic m_close(input bit e);
        logic [31:0] fl;
        logic [3:0] s;
        fl = rdw(m_desc + 8);
        s  = {e, 1'b0, fl[4], fl[4]};
        if (e) fl[11] = 1'b1;
        wrw(m_desc + 8, fl);
        wrw(m_desc + 12, m_ptr);
        if (s != 4'b0) exp_set_q.push_back(s);
        if (fl[0]) wrw(m_ctx + 4, rdw(m_ctx + 4) | 32'h8000);
        else m_load(rdw(m_desc));
    endtask

    task automatic m_byte(input logic [7:0] b, input bit e);
        expm[m_ptr[9:2]][8*m_ptr[1:0] +: 8] = b;
        m_ptr++;
        if (m_ptr == m_after || e) m_close(e);
    endtask

    // per-clock comparison of interrupt outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (intr_set_o != 4'b0) begin
                if (exp_set_q.size() == 0)
                    check(0, "R6", "unexpected intr_set", {28'b0, intr_set_o}, 0);
                else begin
                    logic [3:0] e;
                    e = exp_set_q.pop_front();
                    check(intr_set_o == e, "R6/R7", "intr_set value", {28'b0, intr_set_o}, {28'b0, e});
                end
            end
            if (intr_upd_o != ((raw_intr | intr_set_o) != raw_intr))
                check(0, "R8", "intr_upd", {31'b0, intr_upd_o}, {31'b0, ((raw_intr | intr_set_o) != raw_intr)});
            if (eol_o && in_ready_o)
                check(0, "R10", "ready while eol", 1, 0);
        end
    end

    task automatic do_start(input int d, input int c);
        @(negedge clk);
        start_i = 1'b1; desc_ptr_i = d; ctx_ptr_i = c;
        @(negedge clk);
        start_i = 1'b0;
        m_ctx = c;
        m_load(d);
        check(eol_o == 1'b0 && busy_o == 1'b1, "R1", "start clears eol", {30'b0, eol_o, busy_o}, 1);
    endtask

    task automatic push(input logic [7:0] b, input bit e);
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = b; in_eop_i = e;
        while (!in_ready_o) @(negedge clk);
        m_byte(b, e);
        @(posedge clk);
        #1;
        in_valid_i = 1'b0; in_eop_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic setw(input int a, input logic [31:0] v);
        mem[a[9:2]] = v;
        expm[a[9:2]] = v;
    endtask

    initial begin
        logic [7:0] seq;
        int bp_hits;
        seq = 8'h10;
        for (int i = 0; i < 256; i++) begin mem[i] = 32'hA5A5A5A5; expm[i] = 32'hA5A5A5A5; end
        // next, buf, flags, after
        setw('h000, 'h010); setw('h004, 'h101); setw('h008, 'h10); setw('h00C, 'h107);
        setw('h010, 'h020); setw('h014, 'h200); setw('h018, 'h00); setw('h01C, 'h210);
        setw('h020, 'h030); setw('h024, 'h300); setw('h028, 'h10); setw('h02C, 'h300);
        setw('h030, 'h000); setw('h034, 'h343); setw('h038, 'h11); setw('h03C, 'h348);
        setw('h040, 'h000); setw('h044, 'h380); setw('h048, 'h01); setw('h04C, 'h384);
        setw('h3F4, 'h1);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 0 && mem_req_o == 0 && eol_o == 0 && intr_set_o == 0 && busy_o == 0,
              "R1", "reset state", {27'b0, in_ready_o, mem_req_o, eol_o, busy_o, |intr_set_o}, 0);

        do_start('h000, 'h3F0);
        // D0: unaligned 6-byte buffer, filled exactly (R2, R3)
        for (int i = 0; i < 6; i++) begin push(seq, 1'b0); seq++; end
        // D1: early end-of-packet after 5 bytes (R4, R7); D2 zero length follows (R3, R9)
        for (int i = 0; i < 5; i++) begin push(seq, i == 4); seq++; end
        // D3: end-of-list descriptor, early eop after 3 bytes (R10)
        for (int i = 0; i < 3; i++) begin push(seq, i == 2); seq++; end
        wait_idle();

        check(eol_o == 1'b1, "R10", "eol_o after last descriptor", {31'b0, eol_o}, 1);
        check(mem['h3F4 >> 2] == 32'h8001, "R10", "context disable bit", mem['h3F4 >> 2], 32'h8001);
        check(mem['h01C >> 2] == 32'h205, "R5", "early after field", mem['h01C >> 2], 32'h205);
        check(mem['h018 >> 2] == 32'h800, "R7", "in_eop flag", mem['h018 >> 2], 32'h800);
        check(mem['h00C >> 2] == 32'h107, "R3", "full after field", mem['h00C >> 2], 32'h107);
        check(mem['h02C >> 2] == 32'h300, "R3", "zero-length after", mem['h02C >> 2], 32'h300);
        check(mem['h100 >> 2][7:0] == 8'hA5, "R2", "guard byte below buffer", {24'b0, mem['h100 >> 2][7:0]}, 32'hA5);
        check(mem['h104 >> 2][31:24] == 8'hA5, "R2", "guard byte above buffer", {24'b0, mem['h104 >> 2][31:24]}, 32'hA5);
        check(mem['h300 >> 2] == 32'hA5A5A5A5, "R9", "zero-length buffer untouched", mem['h300 >> 2], 32'hA5A5A5A5);
        check(raw_intr == 4'b1011, "R8", "accumulated raw interrupts", {28'b0, raw_intr}, 32'hB);

        // back-pressure at end of list
        bp_hits = 0;
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = 8'h77;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (in_ready_o) bp_hits++;
        end
        in_valid_i = 1'b0;
        check(bp_hits == 0, "R10", "bytes accepted after eol", bp_hits, 0);

        // restart on a new chain, buffer filled without eop, no interrupt bits
        do_start('h040, 'h3F0);
        for (int i = 0; i < 4; i++) begin push(seq, 1'b0); seq++; end
        wait_idle();
        check(eol_o == 1'b1, "R10", "eol_o after restart chain", {31'b0, eol_o}, 1);
        check(mem['h04C >> 2] == 32'h384, "R5", "after field on restart", mem['h04C >> 2], 32'h384);

        check(exp_set_q.size() == 0, "R6", "interrupt pulses missing", exp_set_q.size(), 0);
        for (int i = 0; i < 256; i++)
            check(mem[i] == expm[i], "R2", $sformatf("memory word %0h", i * 4), mem[i], expm[i]);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule